// File: doc/BRIEF.md
# Windowed Indirect Register Bridge

This block gives a host access to a large internal register space through four 32-bit host-visible registers. The host sees a command register, an address register, a write-data register and a read-data register. To write a target register, the host loads the data, then the target address, then sets the write request bit. To read one, it loads the address and sets the read request bit. The bridge then runs one transaction on a back-end request/response port, whose latency may vary.

When the back end answers, the bridge raises an acknowledge flag. For a read, it captures the returned word at the same moment. The flag stays up, together with the request bit, until the host writes zero to the command register. That zero write returns the bridge to idle, ready for the next transaction.

The host window is addressed by word index: index 0 is the command register (byte offset 0x0), index 1 is the address register (0x4), index 2 is the read-data register (0x8) and index 3 is the write-data register (0xC). Host reads are combinational and have no side effects. On the back end, a request is held with valid until ready is seen. The response is a one-cycle valid pulse, which must come at least one cycle after the request is accepted.

Top module: `rbr_bridge`

## Requirements
- R1: After reset, all four window registers read zero and no back-end request is pending.
- R2: The address register (index 1) and the write-data register (index 3) read back the last value the host wrote to them.
- R3: In idle, a command write with bit 1 set and bit 0 clear starts a write. From the next cycle on, the bridge drives a back-end request with write=1, carrying the address-register and write-data-register values held at the command write.
- R4: Each command starts exactly one back-end request. Valid, address, data and direction stay stable until ready is sampled high, and valid drops in the following cycle.
- R5: In the cycle after the response pulse, the command register reads the request bit with acknowledge bit 2 set. For a read (bit 0), the read-data register holds the response word from that same cycle.
- R6: Writing zero to the command register after acknowledge clears the register to zero, and a new command is accepted from then on.
- R7: While a request or response is outstanding, command writes have no effect. Address and write-data register writes in that time do not change the request in flight.
- R8: A command write with both bit 0 and bit 1 set runs a read. After acknowledge, the command register reads 0x5.
- R9: A non-zero command write while acknowledge is set has no effect; the command register keeps its value.
- R10: The read-data register (index 2) is read-only; host writes to it have no effect.
- R11: A write transaction leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_idx | input | 2 | Window word index (byte offset / 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read of the indexed register |
| be_req_valid | output | 1 | Back-end request valid |
| be_req_ready | input | 1 | Back-end request accepted |
| be_req_write | output | 1 | 1 = write, 0 = read |
| be_req_addr | output | 32 | Back-end register address |
| be_req_wdata | output | 32 | Back-end write data |
| be_rsp_valid | input | 1 | One-cycle completion pulse |
| be_rsp_rdata | input | 32 | Read data returned with the pulse |

## Verification
A host register write takes effect at the clock edge that samples the strobe, so window reads reflect it one cycle later. A command write raises the back-end request at that same edge. The request falls one cycle after the edge that samples ready. Acknowledge and the captured read word appear one cycle after the edge that samples the response pulse.

The bench drives inputs just after the rising edge and updates a behavioural model at the rising edge. It compares every output against that model at the falling edge, so each result is checked in the cycle it becomes due. Directed reads also check fixed expected values at those points.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
    // transaction sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } rbr_state_e;

    // command register bit positions (host visible)
    localparam int unsigned CMD_RD_BIT  = 0;
    localparam int unsigned CMD_WR_BIT  = 1;
    localparam int unsigned CMD_ACK_BIT = 2;
    localparam int unsigned CMD_W       = 3;

    // window word indices
    localparam logic [1:0] IDX_CMD   = 2'd0;
    localparam logic [1:0] IDX_ADDR  = 2'd1;
    localparam logic [1:0] IDX_RDAT  = 2'd2;
    localparam logic [1:0] IDX_WDAT  = 2'd3;
endpackage

// File: rtl/rbr_window.sv
module rbr_window
    import rbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    // to sequencer
    output logic              cmd_we,
    output logic              cmd_zero,
    output logic [1:0]        cmd_req,
    output logic [ADDR_W-1:0] win_addr,
    output logic [DATA_W-1:0] win_wdata,
    // from sequencer
    input  logic [CMD_W-1:0]  cmd_rdback,
    input  logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
    } win_regs_t;

    win_regs_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (host_we && host_idx == IDX_ADDR) win_d.addr = host_wdata[ADDR_W-1:0];
        if (host_we && host_idx == IDX_WDAT) win_d.wdat = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign cmd_we    = host_we && (host_idx == IDX_CMD);
    assign cmd_zero  = (host_wdata == '0);
    assign cmd_req   = {host_wdata[CMD_WR_BIT], host_wdata[CMD_RD_BIT]};
    assign win_addr  = win_q.addr;
    assign win_wdata = win_q.wdat;

    always_comb begin
        unique case (host_idx)
            IDX_CMD:  host_rdata = DATA_W'(cmd_rdback);
            IDX_ADDR: host_rdata = DATA_W'(win_q.addr);
            IDX_RDAT: host_rdata = rd_data;
            default:  host_rdata = win_q.wdat;
        endcase
    end

    // R2: a register write is visible on the next cycle's readback
    a_r2_addr_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_idx == IDX_ADDR) |=> (win_addr == $past(host_wdata[ADDR_W-1:0])));
endmodule

// File: rtl/rbr_seq.sv
module rbr_seq
    import rbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_zero,
    input  logic [1:0]        cmd_req,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [DATA_W-1:0] win_wdata,
    output logic [CMD_W-1:0]  cmd_rdback,
    output logic [DATA_W-1:0] rd_data,
    output logic              be_req_valid,
    input  logic              be_req_ready,
    output logic              be_req_write,
    output logic [ADDR_W-1:0] be_req_addr,
    output logic [DATA_W-1:0] be_req_wdata,
    input  logic              be_rsp_valid,
    input  logic [DATA_W-1:0] be_rsp_rdata
);
    typedef struct packed {
        rbr_state_e        st;
        logic              rd;
        logic              wr;
        logic              ack;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_we && cmd_req != 2'b00) begin
                    s_d.st   = ST_REQ;
                    s_d.rd   = cmd_req[0];   // read wins when both set
                    s_d.wr   = !cmd_req[0];
                    s_d.addr = win_addr;
                    s_d.wdat = win_wdata;
                end
            end
            ST_REQ: begin
                if (be_req_ready) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (be_rsp_valid) begin
                    s_d.st  = ST_DONE;
                    s_d.ack = 1'b1;
                    if (s_q.rd) s_d.rdat = be_rsp_rdata;
                end
            end
            default: begin
                if (cmd_we && cmd_zero) begin
                    s_d.st  = ST_IDLE;
                    s_d.rd  = 1'b0;
                    s_d.wr  = 1'b0;
                    s_d.ack = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_rdback   = {s_q.ack, s_q.wr, s_q.rd};
    assign rd_data      = s_q.rdat;
    assign be_req_valid = (s_q.st == ST_REQ);
    assign be_req_write = s_q.wr;
    assign be_req_addr  = s_q.addr;
    assign be_req_wdata = s_q.wdat;

    // R4: request held stable until accepted
    a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req_valid && !be_req_ready) |=>
            (be_req_valid && $stable(be_req_addr) && $stable(be_req_wdata) && $stable(be_req_write)));

    // R4: one handshake per command
    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req_valid && be_req_ready) |=> !be_req_valid);

    // R5: acknowledge never shown while a request is still pending
    a_r5_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_req_valid && cmd_rdback[CMD_ACK_BIT]));

    // R6: zero write after acknowledge clears the command register
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_zero && cmd_rdback[CMD_ACK_BIT]) |=> (cmd_rdback == '0));

    // R9: acknowledge and request bits persist until a zero write
    a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdback[CMD_ACK_BIT] && !(cmd_we && cmd_zero)) |=> $stable(cmd_rdback));

    // R8/R3: exactly one direction bit while busy or done
    a_r8_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_rdback[1:0]) <= 1);
endmodule

// File: rtl/rbr_bridge.sv
module rbr_bridge
    import rbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              be_req_valid,
    input  logic              be_req_ready,
    output logic              be_req_write,
    output logic [ADDR_W-1:0] be_req_addr,
    output logic [DATA_W-1:0] be_req_wdata,
    input  logic              be_rsp_valid,
    input  logic [DATA_W-1:0] be_rsp_rdata
);
    logic              cmd_we;
    logic              cmd_zero;
    logic [1:0]        cmd_req;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] win_wdata;
    logic [CMD_W-1:0]  cmd_rdback;
    logic [DATA_W-1:0] rd_data;

    rbr_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cmd_we     (cmd_we),
        .cmd_zero   (cmd_zero),
        .cmd_req    (cmd_req),
        .win_addr   (win_addr),
        .win_wdata  (win_wdata),
        .cmd_rdback (cmd_rdback),
        .rd_data    (rd_data)
    );

    rbr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_zero     (cmd_zero),
        .cmd_req      (cmd_req),
        .win_addr     (win_addr),
        .win_wdata    (win_wdata),
        .cmd_rdback   (cmd_rdback),
        .rd_data      (rd_data),
        .be_req_valid (be_req_valid),
        .be_req_ready (be_req_ready),
        .be_req_write (be_req_write),
        .be_req_addr  (be_req_addr),
        .be_req_wdata (be_req_wdata),
        .be_rsp_valid (be_rsp_valid),
        .be_rsp_rdata (be_rsp_rdata)
    );

    // R7: request contents frozen while it is pending
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req_valid && !be_req_ready && host_we) |=> $stable(be_req_addr) && $stable(be_req_wdata));
endmodule

// File: tb/tb_rbr_bridge.sv
module tb_rbr_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_idx = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        be_req_valid;
    logic        be_req_ready = 1'b0;
    logic        be_req_write;
    logic [31:0] be_req_addr;
    logic [31:0] be_req_wdata;
    logic        be_rsp_valid = 1'b0;
    logic [31:0] be_rsp_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    int rdy_lat = 1;
    int rsp_lat = 1;

    always #4 clk = ~clk;  // 125 MHz

    rbr_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
        .be_req_write(be_req_write), .be_req_addr(be_req_addr),
        .be_req_wdata(be_req_wdata), .be_rsp_valid(be_rsp_valid),
        .be_rsp_rdata(be_rsp_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;  // 0 idle, 1 requesting, 2 waiting, 3 acknowledged
    logic [31:0] m_cmd = 0, m_addr = 0, m_wd = 0, m_rd = 0;
    logic [31:0] m_laddr = 0, m_lwd = 0;
    logic        m_lwr = 0;

    always @(posedge clk) begin
        int st0;
        if (!rst_n) begin
            m_st = 0; m_cmd = 0; m_addr = 0; m_wd = 0; m_rd = 0;
            m_laddr = 0; m_lwd = 0; m_lwr = 0;
        end else begin
            st0 = m_st;
            if (st0 == 1 && be_req_ready) m_st = 2;
            else if (st0 == 2 && be_rsp_valid) begin
                m_st = 3;
                m_cmd = m_cmd | 32'h4;
                if (!m_lwr) m_rd = be_rsp_rdata;
            end
            if (host_we) begin
                case (host_idx)
                    2'd0: begin
                        if (st0 == 0 && host_wdata[1:0] != 2'b00) begin
                            m_lwr = !host_wdata[0];
                            m_cmd = host_wdata[0] ? 32'h1 : 32'h2;
                            m_laddr = m_addr; m_lwd = m_wd; m_st = 1;
                        end else if ((st0 == 0 || st0 == 3) && host_wdata == 0) begin
                            m_cmd = 0; m_st = 0;
                        end
                    end
                    2'd1: m_addr = host_wdata;
                    2'd3: m_wd = host_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_view(input logic [1:0] i);
        case (i)
            2'd0: return m_cmd;
            2'd1: return m_addr;
            2'd2: return m_rd;
            default: return m_wd;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R4 req_valid", {31'b0, be_req_valid}, {31'b0, m_st == 1});
            if (m_st == 1) begin
                cmp("R3/R7 req_addr", be_req_addr, m_laddr);
                cmp("R3/R7 req_wdata", be_req_wdata, m_lwd);
                cmp("R3/R8 req_write", {31'b0, be_req_write}, {31'b0, m_lwr});
            end
            cmp("R2 host_rdata", host_rdata, m_view(host_idx));
        end
    end

    // ---------------- back-end responder ----------------
    int ph = 0, cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; be_req_ready = 0; be_rsp_valid = 0;
        end else begin
            case (ph)
                0: if (be_req_valid) begin
                       if (cnt >= rdy_lat) begin be_req_ready = 1; ph = 1; cnt = 0; end
                       else cnt++;
                   end
                1: begin be_req_ready = 0; ph = 2; cnt = 1; end
                2: begin
                       if (cnt >= rsp_lat) begin
                           be_rsp_valid = 1;
                           be_rsp_rdata = be_req_addr ^ 32'h5A5A_0000;
                           ph = 3;
                       end else cnt++;
                   end
                default: begin be_rsp_valid = 0; ph = 0; cnt = 0; end
            endcase
        end
    end

    // ---------------- host tasks ----------------
    task automatic hwr(input logic [1:0] i, input logic [31:0] d);
        @(posedge clk); #1;
        host_we = 1; host_idx = i; host_wdata = d;
        @(posedge clk); #1;
        host_we = 0;
    endtask

    task automatic expect_reg(input logic [1:0] i, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        host_idx = i;
        @(negedge clk);
        cmp(tag, host_rdata, exp);
    endtask

    task automatic wait_ack();
        host_idx = 2'd0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (host_rdata[2]) return;
        end
        cmp("R5 ack timeout", 32'h0, 32'h4);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        for (int i = 0; i < 4; i++) expect_reg(i[1:0], 32'h0, "R1 reset value");

        // R2 + write transaction R3
        hwr(2'd3, 32'hDEAD_BEEF);
        hwr(2'd1, 32'h0000_1000);
        expect_reg(2'd1, 32'h0000_1000, "R2 addr readback");
        expect_reg(2'd3, 32'hDEAD_BEEF, "R2 wdata readback");
        rdy_lat = 3; rsp_lat = 4;
        hwr(2'd0, 32'h2);
        // R7: disturb the window while busy
        hwr(2'd1, 32'h0000_2000);
        hwr(2'd3, 32'h1111_2222);
        hwr(2'd0, 32'h1);
        hwr(2'd0, 32'h0);
        wait_ack();
        expect_reg(2'd0, 32'h6, "R5 write ack");
        expect_reg(2'd2, 32'h0, "R11 rdata untouched by write");
        hwr(2'd0, 32'h1);
        expect_reg(2'd0, 32'h6, "R9 ignored while ack");
        hwr(2'd0, 32'h0);
        expect_reg(2'd0, 32'h0, "R6 cleared");

        // read transaction R5
        rdy_lat = 0; rsp_lat = 1;
        hwr(2'd0, 32'h1);
        wait_ack();
        expect_reg(2'd0, 32'h5, "R5 read ack");
        expect_reg(2'd2, 32'h5A5A_2000, "R5 read data");
        hwr(2'd2, 32'h0000_1234);
        expect_reg(2'd2, 32'h5A5A_2000, "R10 rdata read-only");
        hwr(2'd0, 32'h0);

        // R8: both bits set -> read
        hwr(2'd1, 32'h0000_0040);
        hwr(2'd0, 32'h3);
        wait_ack();
        expect_reg(2'd0, 32'h5, "R8 both bits read");
        expect_reg(2'd2, 32'h5A5A_0040, "R8 read data");
        hwr(2'd0, 32'h0);

        // back-to-back transactions with varied latency
        for (int j = 0; j < 6; j++) begin
            rdy_lat = j % 3; rsp_lat = 1 + (j % 4);
            hwr(2'd3, 32'hC0DE_0000 + j);
            hwr(2'd1, 32'h0000_0100 + 4 * j);
            hwr(2'd0, (j % 2 == 0) ? 32'h2 : 32'h1);
            wait_ack();
            expect_reg(2'd0, (j % 2 == 0) ? 32'h6 : 32'h5, "R5 loop ack");
            hwr(2'd0, 32'h0);
            expect_reg(2'd0, 32'h0, "R6 loop clear");
        end
        expect_reg(2'd2, 32'h5A5A_0114, "R11 last read kept");

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule